// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block turns single-word requests from on-chip logic into correctly timed cycles on an external asynchronous 16-bit static RAM that has separate strobes for its upper and lower bytes. A requester presents an address, a write flag, write data and a per-byte mask while the block reports ready. The block then runs one memory cycle and signals completion with a one-cycle done pulse. For a read, it also returns the captured word.

Every memory-side strobe comes straight from a register, so no combinational glitch reaches the pins. A write is built from four phases, each with its own cycle-count parameter:

- address setup, with write enable still high;
- a write-enable low interval in which the data drivers stay off;
- a data-setup interval in which the enabled bytes are driven;
- a hold interval in which the strobes rise and the data remains on the bus.

A read has two phases. The first is one turnaround cycle in which the chip is selected and output enable stays high. The second is an output-enable interval, and the word is sampled at its last clock edge. Chip enable, write enable and the byte lanes named by the mask must all be low at once for a write to land. The strobes are raised together at a single clock edge, so the write ends at a defined point.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held, and in every idle cycle after it, all of the following hold: `req_ready`=1; `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1; `sram_be_n`=2'b11; `rsp_done`=0; and no data byte is driven.
- R2: A request is taken only at a clock edge where `req_valid` and `req_ready` are both 1. The cycle after it is taken, `req_ready` drops. A `req_valid` raised while the block is busy has no effect on the memory.
- R3: During a write, `sram_we_n` is low for exactly PULSE_CYC consecutive cycles, with `sram_ce_n` low throughout. During those cycles `sram_be_n[i]` = ~`req_mask[i]`, where bit 0 is the low byte `sram_dq[7:0]` and bit 1 is the high byte `sram_dq[15:8]`. Only bytes whose mask bit is 1 change in memory, so mask 2'b00 leaves memory untouched.
- R4: `sram_addr` carries the request address in every cycle in which `sram_ce_n` or `sram_we_n` is low. `sram_we_n` first falls in the (SETUP_CYC+1)-th cycle after acceptance.
- R5: On a write, the masked data bytes are driven only from the last DSETUP_CYC cycles of the write-enable low interval through the hold cycle. The drivers never switch on before `sram_we_n` has been low for at least one cycle.
- R6: During a read, `sram_we_n` stays high. `sram_oe_n` is low for exactly RD_CYC cycles, starting one cycle after `sram_ce_n` falls. The block drives no data byte while `sram_oe_n` is low.
- R7: A read returns `rsp_rdata` in which each byte with mask bit 1 equals the memory content, and each byte with mask bit 0 is zero.
- R8: `rsp_done` is high for one cycle only. For a write it is first seen in cycle SETUP_CYC+PULSE_CYC+HOLD_CYC+1 after the accepting edge. For a read it is first seen in cycle RD_CYC+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Per-byte select, bit 0 = low byte |
| req_ready | output | 1 | Block idle; request will be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read word, unselected bytes zero |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | DATA_W/8 | Byte enables, active low |
| sram_dq | inout | DATA_W | Bidirectional data bus |

## Verification
The bench runs a write to every address of a 16-word memory under every byte mask, then reads each address back under three masks. In every cycle it counts how long each strobe is low and checks the address. A design whose data drivers came on too late would leave the behavioural memory holding the undriven value at the end of the write. A write-enable interval that is one cycle short or long, or a byte enable inverted or on the wrong lane, would corrupt the word read back or break the per-cycle counts. A request raised while the block is busy is aimed at a neighbouring word; if it were accepted, that word would read back changed. A done pulse one cycle early, or held for two cycles, breaks the latency and single-pulse checks.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,   // address setup, write enable high
    ST_WPRE,   // write enable low, drivers off
    ST_WDRV,   // write enable low, drivers on
    ST_WEND,   // strobes high, data still driven
    ST_RTURN,  // chip selected, output enable high
    ST_RSAMP   // output enable low, sample at last edge
  } seq_state_e;
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load || !zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = load_val;
    else if (!zero) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_seq_pkg::*;
#(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state_d,
  input  logic [NB-1:0] mask_d,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [NB-1:0] be_n,
  output logic [NB-1:0] drv_byte
);
  logic          ce_n_d, we_n_d, oe_n_d, drv_d;
  logic [NB-1:0] be_n_d;

  always_comb begin
    ce_n_d = 1'b1;
    we_n_d = 1'b1;
    oe_n_d = 1'b1;
    be_n_d = '1;
    drv_d  = 1'b0;
    unique case (state_d)
      ST_WSET:  begin ce_n_d = 1'b0; be_n_d = ~mask_d; end
      ST_WPRE:  begin ce_n_d = 1'b0; we_n_d = 1'b0; be_n_d = ~mask_d; end
      ST_WDRV:  begin ce_n_d = 1'b0; we_n_d = 1'b0; be_n_d = ~mask_d; drv_d = 1'b1; end
      ST_WEND:  begin drv_d = 1'b1; end
      ST_RTURN: begin ce_n_d = 1'b0; be_n_d = ~mask_d; end
      ST_RSAMP: begin ce_n_d = 1'b0; oe_n_d = 1'b0; be_n_d = ~mask_d; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n     <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      be_n     <= '1;
      drv_byte <= '0;
    end else begin
      ce_n     <= ce_n_d;
      we_n     <= we_n_d;
      oe_n     <= oe_n_d;
      be_n     <= be_n_d;
      drv_byte <= drv_d ? mask_d : '0;
    end
  end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int NB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic [NB-1:0]   mask,
  input  logic [NB*8-1:0] dq_in,
  output logic [NB*8-1:0] rdata
);
  logic [NB*8-1:0] sel;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign sel[b*8 +: 8] = mask[b] ? dq_in[b*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= sel;
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 2,
  parameter int DSETUP_CYC = 1,
  parameter int HOLD_CYC   = 1,
  parameter int RD_CYC     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic                req_ready,
  output logic                rsp_done,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   sram_addr,
  output logic                sram_ce_n,
  output logic                sram_we_n,
  output logic                sram_oe_n,
  output logic [DATA_W/8-1:0] sram_be_n,
  inout  wire  [DATA_W-1:0]   sram_dq
);
  localparam int NB      = DATA_W / 8;
  localparam int PRE_LEN = PULSE_CYC - DSETUP_CYC;
  localparam int MAX_LEN = SETUP_CYC + PULSE_CYC + HOLD_CYC + RD_CYC;
  localparam int TMR_W   = $clog2(MAX_LEN + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  seq_state_e        state_q, state_d;
  logic              tmr_load, tmr_zero, accept, finish, capture;
  logic [TMR_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [NB-1:0]     mask_q, mask_d;
  logic [NB-1:0]     drv_byte;
  logic              done_q;

  function automatic logic [TMR_W-1:0] phase_len_m1(seq_state_e s);
    unique case (s)
      ST_WSET:  return TMR_W'(SETUP_CYC - 1);
      ST_WPRE:  return TMR_W'(PRE_LEN - 1);
      ST_WDRV:  return TMR_W'(DSETUP_CYC - 1);
      ST_WEND:  return TMR_W'(HOLD_CYC - 1);
      ST_RSAMP: return TMR_W'(RD_CYC - 1);
      default:  return '0;
    endcase
  endfunction

  // next-state
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    accept   = 1'b0;
    finish   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        state_d  = req_write ? ST_WSET : ST_RTURN;
      end
      ST_WSET:  if (tmr_zero) begin state_d = ST_WPRE;  tmr_load = 1'b1; end
      ST_WPRE:  if (tmr_zero) begin state_d = ST_WDRV;  tmr_load = 1'b1; end
      ST_WDRV:  if (tmr_zero) begin state_d = ST_WEND;  tmr_load = 1'b1; end
      ST_WEND:  if (tmr_zero) begin state_d = ST_IDLE;  finish   = 1'b1; end
      ST_RTURN: if (tmr_zero) begin state_d = ST_RSAMP; tmr_load = 1'b1; end
      ST_RSAMP: if (tmr_zero) begin
        state_d = ST_IDLE;
        finish  = 1'b1;
        capture = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_val = phase_len_m1(state_d);
  assign mask_d  = accept ? req_mask : mask_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
    end
  end

  // request register, enabled on acceptance
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  sram_phase_timer #(.W(TMR_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_strobe_gen #(.NB(NB)) strobe_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .state_d  (state_d),
    .mask_d   (mask_d),
    .ce_n     (sram_ce_n),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .be_n     (sram_be_n),
    .drv_byte (drv_byte)
  );

  sram_rd_capture #(.NB(NB)) capture_i (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .cap_en (capture),
    .mask   (mask_q),
    .dq_in  (sram_dq),
    .rdata  (rsp_rdata)
  );

  for (genvar b = 0; b < NB; b++) begin : g_drv
    assign sram_dq[b*8 +: 8] = drv_byte[b] ? wdata_q[b*8 +: 8] : 8'bz;
  end

  assign sram_addr = addr_q;
  assign req_ready = (state_q == ST_IDLE);
  assign rsp_done  = done_q;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
  parameter int NB        = 2,
  parameter int PULSE_CYC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_done,
  input logic          sram_ce_n,
  input logic          sram_we_n,
  input logic          sram_oe_n,
  input logic [NB-1:0] sram_be_n,
  input logic [NB-1:0] drv_byte
);
  logic [7:0] we_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low_cnt <= '0;
    else if (sram_we_n) we_low_cnt <= '0;
    else                we_low_cnt <= we_low_cnt + 8'd1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && sram_be_n == '1 && drv_byte == '0));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);

  // R3
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low_cnt == 8'(PULSE_CYC)));

  // R5
  drive_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|drv_byte) |-> (!sram_we_n && !$past(sram_we_n)));

  // R6
  read_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> sram_we_n);

  // R6
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (drv_byte == '0));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.NB(NB), .PULSE_CYC(PULSE_CYC)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .sram_ce_n (sram_ce_n),
  .sram_we_n (sram_we_n),
  .sram_oe_n (sram_oe_n),
  .sram_be_n (sram_be_n),
  .drv_byte  (drv_byte)
);

// File: tb/sram_seq_ctrl_tb_top.sv
module sram_seq_ctrl_tb_top;
  localparam int AW = 4;
  localparam int S  = 1;
  localparam int P  = 3;
  localparam int D  = 1;
  localparam int H  = 1;
  localparam int R  = 2;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_mask = '0;
  logic          req_ready, rsp_done;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n, sram_we_n, sram_oe_n;
  logic [1:0]    sram_be_n;
  wire  [15:0]   sram_dq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  sram_seq_ctrl #(
    .ADDR_W(AW), .DATA_W(16), .SETUP_CYC(S), .PULSE_CYC(P),
    .DSETUP_CYC(D), .HOLD_CYC(H), .RD_CYC(R)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_be_n(sram_be_n), .sram_dq(sram_dq)
  );

  // behavioural memory: write lands when the overlap of strobes ends
  logic [15:0]   mem [WORDS];
  logic [15:0]   refm [WORDS];
  logic [1:0]    ov_was = '0;
  logic [15:0]   pend = '0;
  logic [AW-1:0] pend_addr = '0;

  for (genvar b = 0; b < 2; b++) begin : g_mdl
    assign sram_dq[b*8 +: 8] = (!sram_ce_n && !sram_oe_n && sram_we_n && !sram_be_n[b])
                               ? mem[sram_addr][b*8 +: 8] : 8'bz;
  end

  always @(negedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (!sram_ce_n && !sram_we_n && !sram_be_n[b]) begin
        pend[b*8 +: 8] <= sram_dq[b*8 +: 8];
        pend_addr      <= sram_addr;
        ov_was[b]      <= 1'b1;
      end else if (ov_was[b]) begin
        mem[pend_addr][b*8 +: 8] <= pend[b*8 +: 8];
        ov_was[b]                <= 1'b0;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lanes(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic run_txn(input logic wr, input int a, input logic [15:0] d,
                         input logic [1:0] m, input bit intrude);
    int we_lo = 0, oe_lo = 0, ce_lo = 0, done_at = 0, we_first = 0;
    logic [15:0] got = '0;
    @(negedge clk);
    chk("R2", "ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n <= 40; n++) begin
      if (!sram_we_n) begin
        we_lo++;
        if (we_first == 0) we_first = n;
        chk("R3", "byte enables during write", {30'd0, sram_be_n}, {30'd0, ~m});
      end
      if (!sram_oe_n) oe_lo++;
      if (!sram_ce_n) ce_lo++;
      if (!sram_ce_n || !sram_we_n)
        chk("R4", "address held", {28'd0, sram_addr}, 32'(a));
      if (rsp_done) begin
        done_at = n;
        got = rsp_rdata;
        break;
      end
      if (intrude && n == 1) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'((a + 1) % WORDS);
        req_wdata = 16'hDEAD; req_mask = 2'b11;
      end
      if (intrude && n == 2) req_valid = 1'b0;
      @(negedge clk);
    end
    if (wr) begin
      chk("R8", "write done cycle", 32'(done_at), 32'(S + P + H + 1));
      chk("R3", "write enable width", 32'(we_lo), 32'(P));
      chk("R4", "write enable start", 32'(we_first), 32'(S + 1));
      chk("R6", "no output enable on write", 32'(oe_lo), 32'd0);
      refm[a] = (refm[a] & ~lanes(m)) | (d & lanes(m));
    end else begin
      chk("R8", "read done cycle", 32'(done_at), 32'(R + 2));
      chk("R6", "output enable width", 32'(oe_lo), 32'(R));
      chk("R6", "chip enable on read", 32'(ce_lo), 32'(R + 1));
      chk("R6", "write enable high on read", 32'(we_lo), 32'd0);
      chk("R7", "read data", {16'd0, got}, {16'd0, refm[a] & lanes(m)});
    end
    @(negedge clk);
    chk("R8", "done lasts one cycle", {31'd0, rsp_done}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      mem[i]  = 16'h5A5A ^ 16'(i * 16'h0101);
      refm[i] = 16'h5A5A ^ 16'(i * 16'h0101);
    end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R1", "strobes in reset", {28'd0, sram_ce_n, sram_we_n, sram_oe_n, 1'b1}, 32'hF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R1", "strobes idle", {27'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_be_n}, 32'h1F);
    chk("R1", "done idle", {31'd0, rsp_done}, 32'd0);
    chk("R1", "read data cleared", {16'd0, rsp_rdata}, 32'd0);

    // every address, every mask (mask 00 must change nothing: R3)
    for (int a = 0; a < WORDS; a++)
      for (int m = 0; m < 4; m++)
        run_txn(1'b1, a, 16'((a * 16'h1357) ^ (m * 16'h2468) ^ 16'h0F0F), 2'(m), 1'b0);
    for (int a = 0; a < WORDS; a++)
      for (int m = 1; m < 4; m++)
        run_txn(1'b0, a, 16'h0, 2'(m), 1'b0);

    // R2: request raised while busy must not reach the neighbouring word
    run_txn(1'b1, 3, 16'h1234, 2'b11, 1'b1);
    run_txn(1'b0, 4, 16'h0, 2'b11, 1'b0);
    run_txn(1'b0, 3, 16'h0, 2'b11, 1'b0);
    run_txn(1'b0, 9, 16'h0, 2'b11, 1'b1);
    run_txn(1'b0, 10, 16'h0, 2'b11, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule